// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block collects event pulses from a generator and turns them into one interrupt line through two cascaded levels. The first level holds three sticky source flags (generation done, health-test failure, entropy-test failure), each with its own enable bit. The second level holds a top status word. Its bit 0 is a core summary bit, recomputed on every clock edge as "any source flag that is also enabled". Its bit 1 is a sticky bus-error event bit. A mask word gates the top status onto the `irq` output.

Software reaches the block through a simple word-addressed 32-bit write port and a combinational read port. The mask cannot be written directly. Bits are opened through an unmask register and closed through a mask-set register, and both of these read back as zero. A soft-clear input wipes the first level and the core bit. It leaves the enables, the bus-error bit and the mask untouched.

Top module: `irqc_two_level`

## Requirements
- R1: After the synchronous active-low reset, the control word (address 0), the source flags (address 1) and the top status (address 2) read 0. The mask (address 3) reads 0x3 and `irq` is 0. Unused addresses read 0.
- R2: A high `src_evt[i]` sets source flag i on the next edge, and the flag stays set. Flag bit 0 is done, bit 1 is health failure and bit 2 is entropy failure, and they are read at address 1.
- R3: A write to address 0 stores bits 2:0 as the enables for source flags 0..2. Writing 1 to bit 3, 4 or 5 clears source flag 0, 1 or 2. Reading address 0 returns the enables with bits 5:3 as 0.
- R4: Top status bit 0 equals the OR of (source flag AND its enable), and is updated on the same edge as the flags and enables. A write-1-to-clear of bit 0 cannot hold it low while an enabled flag remains set.
- R5: A high `bus_err_evt` sets top status bit 1 on the next edge, and the bit stays set. Writing 1 to bit 1 of address 2 clears it.
- R6: The mask resets to 0x3, meaning all masked, and is unchanged by any write to address 3.
- R7: A write to address 4 clears the written bits of the mask. A write to address 5 sets the written bits of the mask. Addresses 4 and 5 read 0.
- R8: `irq` is 1 exactly when some top status bit is 1 and its mask bit is 0. It follows the registers on the same edge.
- R9: When an event and a write-1-to-clear hit the same flag or top bit in the same cycle, the bit ends up set.
- R10: A high `soft_clr` clears all source flags and top bit 0 on the next edge, overriding events. It leaves the enables, the bus-error bit and the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Clears the first level and the core bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Combinational read data |
| src_evt | input | 3 | Set pulses for done, health failure, entropy failure |
| bus_err_evt | input | 1 | Set pulse for the bus-error top bit |
| irq | output | 1 | Interrupt line |

## Verification
Every result of this block is due one clock edge after its stimulus: flags, the core bit, the top status, the mask and `irq` all settle on the edge that samples the write or event. The reason is that the core bit is computed from the next-state flags and enables. The driver applies each stimulus at a falling edge and lets exactly one rising edge pass. It then queues the expected register and `irq` values, and the monitor compares them at the following falling edge. Same-cycle collisions (an event against a clear, soft clear against an event) are driven within one cycle so that the priority is visible in that single update.

// File: rtl/irqc_pkg.sv
// Package: shared sizes, register addresses and top-status bit positions
// for the two-level interrupt controller.
package irqc_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int N_SRC     = 3;
    localparam int N_TOP     = 2;
    localparam int TOP_CORE  = 0;
    localparam int TOP_BUSER = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTL     = 4'd0,
        A_FLAGS   = 4'd1,
        A_TOP     = 4'd2,
        A_MASK    = 4'd3,
        A_UNMASK  = 4'd4,
        A_MASKSET = 4'd5
    } reg_addr_e;
endpackage

// File: rtl/irqc_regif.sv
// Module: irqc_regif
// Decodes single-cycle register writes into strobes for the two levels.
// Provides the combinational read mux.
// Assumes: one write per cycle at most; reads have no side effects.
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int NSRC = N_SRC,
    parameter int NTOP = N_TOP
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic [NSRC-1:0]   en_q,
    input  logic [NSRC-1:0]   flags_q,
    input  logic [NTOP-1:0]   top_q,
    input  logic [NTOP-1:0]   mask_q,
    output logic              ctl_wr,
    output logic [2*NSRC-1:0] ctl_data,
    output logic [NTOP-1:0]   top_w1c,
    output logic [NTOP-1:0]   unmask_bits,
    output logic [NTOP-1:0]   maskset_bits,
    output logic [DW-1:0]     rd_data
);
    reg_addr_e wsel;
    reg_addr_e rsel;

    assign wsel = reg_addr_e'(wr_addr);
    assign rsel = reg_addr_e'(rd_addr);

    // Purpose: turn a write into one-cycle strobes per register.
    always_comb begin
        ctl_wr       = 1'b0;
        ctl_data     = wr_data[2*NSRC-1:0];
        top_w1c      = '0;
        unmask_bits  = '0;
        maskset_bits = '0;
        if (wr_en) begin
            case (wsel)
                A_CTL:     ctl_wr       = 1'b1;
                A_TOP:     top_w1c      = wr_data[NTOP-1:0];
                A_UNMASK:  unmask_bits  = wr_data[NTOP-1:0];
                A_MASKSET: maskset_bits = wr_data[NTOP-1:0];
                default:   ;
            endcase
        end
    end

    // Purpose: read mux; clear bits, unmask and mask-set read as zero.
    always_comb begin
        rd_data = '0;
        case (rsel)
            A_CTL:   rd_data[NSRC-1:0] = en_q;
            A_FLAGS: rd_data[NSRC-1:0] = flags_q;
            A_TOP:   rd_data[NTOP-1:0] = top_q;
            A_MASK:  rd_data[NTOP-1:0] = mask_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irqc_src_flags.sv
// Module: irqc_src_flags
// First level: sticky source flags with per-flag enable and self-acting clear.
// Exposes the next-state summary so the core bit lands on the same edge.
// Assumes: priority per flag is soft clear, then event, then clear bit.
module irqc_src_flags #(
    parameter int NSRC = irqc_pkg::N_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              ctl_wr,
    input  logic [2*NSRC-1:0] ctl_data,
    input  logic [NSRC-1:0]   evt,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   flags_q,
    output logic              core_next
);
    logic [NSRC-1:0] en_next;
    logic [NSRC-1:0] flag_next;

    // Purpose: enable register, loaded by every control-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (ctl_wr) en_q <= ctl_data[NSRC-1:0];
    end

    assign en_next = ctl_wr ? ctl_data[NSRC-1:0] : en_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic clr_i;
        assign clr_i = ctl_wr & ctl_data[NSRC+i];

        // Purpose: next value of flag i (soft clear > event > clear bit).
        always_comb begin
            if (soft_clr)   flag_next[i] = 1'b0;
            else if (evt[i]) flag_next[i] = 1'b1;
            else if (clr_i)  flag_next[i] = 1'b0;
            else             flag_next[i] = flags_q[i];
        end

        // Purpose: flag i storage.
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= flag_next[i];
        end

        a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !soft_clr) |=> flags_q[i]);
        a_r3_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !evt[i] && !soft_clr) |=> !flags_q[i]);
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && evt[i] && !soft_clr) |=> flags_q[i]);
    end

    assign core_next = |(flag_next & en_next);

    a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(en_q));
endmodule

// File: rtl/irqc_top_level.sv
// Module: irqc_top_level
// Second level: top status (core bit tracks level one, other bits sticky W1C),
// the mask driven only by unmask/mask-set strobes, and the irq output.
// Assumes: core_next already reflects soft clear and same-edge updates.
module irqc_top_level
    import irqc_pkg::*;
#(
    parameter int NTOP = N_TOP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_next,
    input  logic [NTOP-1:0] side_evt,
    input  logic [NTOP-1:0] top_w1c,
    input  logic [NTOP-1:0] unmask_bits,
    input  logic [NTOP-1:0] maskset_bits,
    output logic [NTOP-1:0] top_q,
    output logic [NTOP-1:0] mask_q,
    output logic            irq
);
    localparam logic [NTOP-1:0] MASK_RST = {NTOP{1'b1}};

    for (genvar b = 0; b < NTOP; b++) begin : g_top
        if (b == TOP_CORE) begin : g_core
            // Purpose: core bit follows the level-one summary every edge.
            always_ff @(posedge clk) begin
                if (!rst_n) top_q[b] <= 1'b0;
                else        top_q[b] <= core_next;
            end
        end else begin : g_sticky
            // Purpose: sticky event bit, set wins over write-1-to-clear.
            always_ff @(posedge clk) begin
                if (!rst_n)           top_q[b] <= 1'b0;
                else if (side_evt[b]) top_q[b] <= 1'b1;
                else if (top_w1c[b])  top_q[b] <= 1'b0;
            end

            a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                side_evt[b] |=> top_q[b]);
            a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
                (top_w1c[b] && !side_evt[b]) |=> !top_q[b]);
        end
    end

    // Purpose: mask changes only through the unmask and mask-set strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= MASK_RST;
        else        mask_q <= (mask_q & ~unmask_bits) | maskset_bits;
    end

    // Purpose: interrupt line from unmasked top status.
    assign irq = |(top_q & ~mask_q);

    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_bits == '0 && maskset_bits == '0) |=> $stable(mask_q));
    a_r7_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_bits != '0 && maskset_bits == '0) |=> ((mask_q & $past(unmask_bits)) == '0));
    a_r7_maskset: assert property (@(posedge clk) disable iff (!rst_n)
        (maskset_bits != '0) |=> ((mask_q & $past(maskset_bits)) == $past(maskset_bits)));
    a_r8_irq_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == MASK_RST) |-> !irq);
endmodule

// File: rtl/irqc_two_level.sv
// Module: irqc_two_level
// Top of the two-level interrupt controller: register decode, level-one
// source flags and the level-two status/mask stage.
// Assumes: synchronous active-low reset; event inputs are one-cycle pulses
// or levels sampled each edge.
module irqc_two_level
    import irqc_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int NSRC = N_SRC,
    parameter int NTOP = N_TOP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [NSRC-1:0] src_evt,
    input  logic            bus_err_evt,
    output logic            irq
);
    logic              ctl_wr;
    logic [2*NSRC-1:0] ctl_data;
    logic [NTOP-1:0]   top_w1c;
    logic [NTOP-1:0]   unmask_bits;
    logic [NTOP-1:0]   maskset_bits;
    logic [NSRC-1:0]   en_q;
    logic [NSRC-1:0]   flags_q;
    logic              core_next;
    logic [NTOP-1:0]   top_q;
    logic [NTOP-1:0]   mask_q;
    logic [NTOP-1:0]   side_evt;

    // Purpose: route the bus-error pulse to its top bit; core slot unused.
    always_comb begin
        side_evt            = '0;
        side_evt[TOP_BUSER] = bus_err_evt;
    end

    irqc_regif #(.DW(DW), .AW(AW), .NSRC(NSRC), .NTOP(NTOP)) u_regif (
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .en_q        (en_q),
        .flags_q     (flags_q),
        .top_q       (top_q),
        .mask_q      (mask_q),
        .ctl_wr      (ctl_wr),
        .ctl_data    (ctl_data),
        .top_w1c     (top_w1c),
        .unmask_bits (unmask_bits),
        .maskset_bits(maskset_bits),
        .rd_data     (rd_data)
    );

    irqc_src_flags #(.NSRC(NSRC)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .evt      (src_evt),
        .en_q     (en_q),
        .flags_q  (flags_q),
        .core_next(core_next)
    );

    irqc_top_level #(.NTOP(NTOP)) u_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_next   (core_next),
        .side_evt    (side_evt),
        .top_w1c     (top_w1c),
        .unmask_bits (unmask_bits),
        .maskset_bits(maskset_bits),
        .top_q       (top_q),
        .mask_q      (mask_q),
        .irq         (irq)
    );

    a_r4_core_match: assert property (@(posedge clk) disable iff (!rst_n)
        top_q[TOP_CORE] == |(flags_q & en_q));
    a_r10_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (flags_q == '0 && !top_q[TOP_CORE]));
    a_r10_soft_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr && !wr_en) |=> $stable(mask_q));
endmodule

// File: tb/irqc_two_level_tb_top.sv
// Scoreboard bench: the driver applies one stimulus per cycle and queues
// expected reads; the monitor pops them at the next falling edge and compares.
module irqc_two_level_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  src_evt = '0;
    logic        bus_err_evt = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        string       req;
        logic [3:0]  addr;
        logic [31:0] val;
        logic        irq_exp;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    irqc_two_level dut_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .src_evt(src_evt), .bus_err_evt(bus_err_evt), .irq(irq)
    );

    // Monitor: compare queued expectations away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                #1;
                n_tests++;
                if (rd_data !== it.val || irq !== it.irq_exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d data %h irq %b, expected data %h irq %b",
                             it.req, it.addr, rd_data, irq, it.val, it.irq_exp);
                end
            end
        end
    end

    task automatic exp_reg(input string req, input logic [3:0] a,
                           input logic [31:0] v, input logic ie);
        item_t it;
        it.req = req; it.addr = a; it.val = v; it.irq_exp = ie;
        sb_q.push_back(it);
    endtask

    // One stimulus cycle: drive at falling edge, release after the rising edge.
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic [2:0] ev, input logic be, input logic sc);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        src_evt = ev; bus_err_evt = be; soft_clr = sc;
        @(posedge clk);
        #1;
        wr_en = 1'b0; src_evt = '0; bus_err_evt = 1'b0; soft_clr = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        wait (sb_q.size() == 0);
        #3;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        exp_reg("R1 ctl", 4'd0, 32'h0, 1'b0);
        exp_reg("R1 flags", 4'd1, 32'h0, 1'b0);
        exp_reg("R1 top", 4'd2, 32'h0, 1'b0);
        exp_reg("R1 mask", 4'd3, 32'h3, 1'b0);
        exp_reg("R1 unused", 4'd9, 32'h0, 1'b0);
        drain();

        // R2 done event with enable off: flag set, core stays 0 (R4)
        step(1'b0, 4'd0, 32'h0, 3'b001, 1'b0, 1'b0);
        exp_reg("R2 done flag", 4'd1, 32'h1, 1'b0);
        exp_reg("R4 core off without enable", 4'd2, 32'h0, 1'b0);
        drain();

        // R3/R4 enable done: core rises on the same edge, still masked (R8)
        step(1'b1, 4'd0, 32'h1, 3'b000, 1'b0, 1'b0);
        exp_reg("R3 enable readback", 4'd0, 32'h1, 1'b0);
        exp_reg("R4 core follows enable", 4'd2, 32'h1, 1'b0);
        drain();

        // R7 unmask bit 0: irq rises (R8)
        step(1'b1, 4'd4, 32'h1, 3'b000, 1'b0, 1'b0);
        exp_reg("R7 unmask clears bit", 4'd3, 32'h2, 1'b1);
        exp_reg("R7 unmask reads zero", 4'd4, 32'h0, 1'b1);
        drain();

        // R6 direct mask write ignored
        step(1'b1, 4'd3, 32'h0, 3'b000, 1'b0, 1'b0);
        exp_reg("R6 mask write ignored", 4'd3, 32'h2, 1'b1);
        drain();

        // R4 W1C of core bit cannot hold it low
        step(1'b1, 4'd2, 32'h1, 3'b000, 1'b0, 1'b0);
        exp_reg("R4 core w1c while source set", 4'd2, 32'h1, 1'b1);
        drain();

        // R3 clear done via bit 3, keep enable
        step(1'b1, 4'd0, 32'h9, 3'b000, 1'b0, 1'b0);
        exp_reg("R3 clear done flag", 4'd1, 32'h0, 1'b0);
        exp_reg("R3 clear bits read zero", 4'd0, 32'h1, 1'b0);
        exp_reg("R4 core drops", 4'd2, 32'h0, 1'b0);
        drain();

        // R2 health and entropy events, not enabled
        step(1'b0, 4'd0, 32'h0, 3'b110, 1'b0, 1'b0);
        exp_reg("R2 two flags", 4'd1, 32'h6, 1'b0);
        exp_reg("R4 core off, flags disabled", 4'd2, 32'h0, 1'b0);
        drain();

        step(1'b1, 4'd0, 32'h6, 3'b000, 1'b0, 1'b0);
        exp_reg("R4 core from health/entropy", 4'd2, 32'h1, 1'b1);
        drain();

        // R9 health event and health clear same cycle: set wins
        step(1'b1, 4'd0, 32'h16, 3'b010, 1'b0, 1'b0);
        exp_reg("R9 flag set wins", 4'd1, 32'h6, 1'b1);
        drain();

        // R3 clear entropy only
        step(1'b1, 4'd0, 32'h26, 3'b000, 1'b0, 1'b0);
        exp_reg("R3 clear entropy flag", 4'd1, 32'h2, 1'b1);
        drain();

        // R5 bus error sets top bit 1
        step(1'b0, 4'd0, 32'h0, 3'b000, 1'b1, 1'b0);
        exp_reg("R5 bus error bit", 4'd2, 32'h3, 1'b1);
        drain();

        // R7 mask-set bit 0: everything masked again
        step(1'b1, 4'd5, 32'h1, 3'b000, 1'b0, 1'b0);
        exp_reg("R7 mask-set sets bit", 4'd3, 32'h3, 1'b0);
        exp_reg("R7 mask-set reads zero", 4'd5, 32'h0, 1'b0);
        drain();

        // R8 open bit 1 only: irq from bus error
        step(1'b1, 4'd4, 32'h2, 3'b000, 1'b0, 1'b0);
        exp_reg("R8 irq from bus error", 4'd3, 32'h1, 1'b1);
        drain();

        // R9 bus error and its W1C same cycle: set wins
        step(1'b1, 4'd2, 32'h2, 3'b000, 1'b1, 1'b0);
        exp_reg("R9 top set wins", 4'd2, 32'h3, 1'b1);
        drain();

        // R5 W1C clears bus error, core masked so irq drops
        step(1'b1, 4'd2, 32'h2, 3'b000, 1'b0, 1'b0);
        exp_reg("R5 bus error cleared", 4'd2, 32'h1, 1'b0);
        drain();

        step(1'b0, 4'd0, 32'h0, 3'b000, 1'b1, 1'b0);
        exp_reg("R5 bus error again", 4'd2, 32'h3, 1'b1);
        drain();

        // R10 soft clear with a done event: flags and core clear, rest kept
        step(1'b0, 4'd0, 32'h0, 3'b001, 1'b0, 1'b1);
        exp_reg("R10 flags cleared", 4'd1, 32'h0, 1'b1);
        exp_reg("R10 core cleared, bus error kept", 4'd2, 32'h2, 1'b1);
        exp_reg("R10 mask kept", 4'd3, 32'h1, 1'b1);
        exp_reg("R10 enables kept", 4'd0, 32'h6, 1'b1);
        drain();

        step(1'b1, 4'd2, 32'h2, 3'b000, 1'b0, 1'b0);
        exp_reg("R8 irq low when top empty", 4'd2, 32'h0, 1'b0);
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule